// File: doc/BRIEF.md
# L2 Encapsulation Tag Editor

This unit holds the layer-2 portion of a forwarding flow entry and edits it in place as tag-push commands arrive. The entry is made of an ethertype word, two VLAN ID slots, a PPPoE session ID, a two-bit count of tag layers, a flag recording that the first layer is a true VLAN tag, and a flag recording that a PPPoE session header is present. Three push commands exist: a switch port tag, a VLAN tag and a PPPoE session. They share the single ethertype word. A port tag is written as a one-hot bit at the port number. Bit 8 of the ethertype marks that one more tag sits behind it.

A flow-setup engine first loads the entry with the initial ethertype for its flow family, IPv4 or IPv6. It then issues at most one push per cycle. Each push changes the entry on the next clock edge. A registered response in the next cycle reports success, or a no-space error when no VLAN slot is left. The edited fields are visible on the outputs at all times, for the logic that serialises the entry.

Top module: `l2_tag_editor`

## Requirements
- R1: After reset the ethertype is 0x0800 and every other field and flag is zero. With init_i high, the next edge loads ethertype 0x86DD when init_v6_i is 1 and 0x0800 when it is 0, and clears every other field. A command presented in the same cycle is dropped and gives no response.
- R2: A port-tag push (cmd_op_i = 2'b01) sets the ethertype to the one-hot value 1 << cmd_port_i. At layer count 0 it sets the layer count to 1. At any other layer count it keeps the layer count and also sets ethertype bit 8. In both cases it clears the VLAN-tag flag.
- R3: A VLAN push (cmd_op_i = 2'b10) at layer count 0 stores cmd_vid_i in VLAN slot 1, sets the VLAN-tag flag and sets the layer count to 1.
- R4: A VLAN push at layer count 1 with the VLAN-tag flag clear stores the ID in VLAN slot 1 and sets ethertype bit 8. The layer count stays 1.
- R5: A VLAN push at layer count 1 with the VLAN-tag flag set stores the ID in VLAN slot 2 and raises the layer count to 2.
- R6: A VLAN push at layer count 2 or more responds with rsp_err_o = 1 and leaves every field unchanged.
- R7: A PPPoE push (cmd_op_i = 2'b11) replaces the ethertype with 0x8864 when the layer count is 0 or the VLAN-tag flag is set, and leaves it alone otherwise. It always sets the PPPoE flag and stores cmd_sid_i.
- R8: rsp_valid_o is high in the cycle after each accepted command and low otherwise. rsp_err_o is high only for the case in R6.
- R9: The layer count never exceeds 2.
- R10: The no-operation code (cmd_op_i = 2'b00) returns a good response and changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Load the initial entry |
| init_v6_i | input | 1 | Flow family for init: 1 = IPv6, 0 = IPv4 |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | 00 nop, 01 port tag, 10 VLAN, 11 PPPoE |
| cmd_port_i | input | 3 | Switch port number for a port-tag push |
| cmd_vid_i | input | 12 | VLAN ID for a VLAN push |
| cmd_sid_i | input | 16 | Session ID for a PPPoE push |
| rsp_valid_o | output | 1 | Response for the previous cycle's command |
| rsp_err_o | output | 1 | No-space error |
| etype_o | output | 16 | Ethertype / port-tag word |
| vlan1_o | output | 12 | VLAN slot 1 |
| vlan2_o | output | 12 | VLAN slot 2 |
| sid_o | output | 16 | PPPoE session ID |
| layers_o | output | 2 | Tag layer count |
| vtag_o | output | 1 | First layer is a VLAN tag |
| pppoe_o | output | 1 | PPPoE header present |

## Verification
Every field is an output, so a wrong layer count or a lost VLAN-tag flag shows up on the ports one edge after the push that caused it. The same fault also changes the result of every later push: a stale flag sends the next VLAN ID to the wrong slot, or leaves the PPPoE ethertype unwritten. Long random push sequences that pass through re-initialisation reach all the layer-count and flag combinations. The bench compares the whole entry and the response after every edge.

// File: rtl/l2te_pkg.sv
package l2te_pkg;
  parameter int ETYPE_W = 16;
  parameter int VID_W   = 12;
  parameter int SID_W   = 16;
  parameter int PORT_W  = 3;
  parameter int LAYER_W = 2;

  localparam int MARK_BIT   = 8;
  localparam int MAX_LAYERS = 2;

  localparam logic [ETYPE_W-1:0] ETYPE_V4    = 16'h0800;
  localparam logic [ETYPE_W-1:0] ETYPE_V6    = 16'h86DD;
  localparam logic [ETYPE_W-1:0] ETYPE_PPPOE = 16'h8864;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_PORT  = 2'b01,
    OP_VLAN  = 2'b10,
    OP_PPPOE = 2'b11
  } op_e;

  typedef struct packed {
    logic [ETYPE_W-1:0] etype;
    logic [VID_W-1:0]   vlan1;
    logic [VID_W-1:0]   vlan2;
    logic [SID_W-1:0]   sid;
    logic [LAYER_W-1:0] layers;
    logic               vtag;
    logic               pppoe;
  } entry_t;

  function automatic entry_t fresh_entry(input logic v6);
    entry_t e;
    e       = '0;
    e.etype = v6 ? ETYPE_V6 : ETYPE_V4;
    return e;
  endfunction
endpackage

// File: rtl/l2te_port_push.sv
module l2te_port_push
  import l2te_pkg::*;
(
  input  entry_t            cur_i,
  input  logic [PORT_W-1:0] port_i,
  output entry_t            nxt_o
);
  always_comb begin
    nxt_o               = cur_i;
    nxt_o.etype         = '0;
    nxt_o.etype[port_i] = 1'b1;
    if (cur_i.layers == '0) begin
      nxt_o.layers = LAYER_W'(1);
    end else begin
      nxt_o.etype[MARK_BIT] = 1'b1;
    end
    nxt_o.vtag = 1'b0;
  end
endmodule

// File: rtl/l2te_vlan_push.sv
module l2te_vlan_push
  import l2te_pkg::*;
(
  input  entry_t           cur_i,
  input  logic [VID_W-1:0] vid_i,
  output entry_t           nxt_o,
  output logic             full_o
);
  always_comb begin
    nxt_o  = cur_i;
    full_o = 1'b0;
    if (cur_i.layers == '0) begin
      nxt_o.vtag   = 1'b1;
      nxt_o.layers = LAYER_W'(1);
      nxt_o.vlan1  = vid_i;
    end else if (cur_i.layers == LAYER_W'(1)) begin
      if (!cur_i.vtag) begin
        // port tag occupies layer 1: VLAN goes behind it
        nxt_o.vlan1           = vid_i;
        nxt_o.etype[MARK_BIT] = 1'b1;
      end else begin
        nxt_o.vlan2  = vid_i;
        nxt_o.layers = LAYER_W'(MAX_LAYERS);
      end
    end else begin
      full_o = 1'b1;
    end
  end
endmodule

// File: rtl/l2te_pppoe_push.sv
module l2te_pppoe_push
  import l2te_pkg::*;
(
  input  entry_t           cur_i,
  input  logic [SID_W-1:0] sid_i,
  output entry_t           nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (cur_i.layers == '0 || cur_i.vtag) nxt_o.etype = ETYPE_PPPOE;
    nxt_o.pppoe = 1'b1;
    nxt_o.sid   = sid_i;
  end
endmodule

// File: rtl/l2te_entry_reg.sv
module l2te_entry_reg
  import l2te_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              init_v6_i,
  input  logic              cmd_valid_i,
  input  op_e               cmd_op_i,
  input  logic [PORT_W-1:0] cmd_port_i,
  input  logic [SID_W-1:0]  cmd_sid_i,
  input  entry_t            port_nxt_i,
  input  entry_t            vlan_nxt_i,
  input  logic              vlan_full_i,
  input  entry_t            pppoe_nxt_i,
  output entry_t            ent_o,
  output logic              rsp_valid_o,
  output logic              rsp_err_o
);
  entry_t sel_nxt;
  logic   sel_err;
  logic   take;

  always_comb begin
    sel_nxt = ent_o;
    sel_err = 1'b0;
    unique case (cmd_op_i)
      OP_PORT:  sel_nxt = port_nxt_i;
      OP_VLAN:  begin sel_nxt = vlan_nxt_i; sel_err = vlan_full_i; end
      OP_PPPOE: sel_nxt = pppoe_nxt_i;
      default:  sel_nxt = ent_o;
    endcase
  end

  assign take = cmd_valid_i && !init_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_o       <= fresh_entry(1'b0);
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
    end else if (init_i) begin
      ent_o       <= fresh_entry(init_v6_i);
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= cmd_valid_i;
      rsp_err_o   <= cmd_valid_i && sel_err;
      if (cmd_valid_i && !sel_err) ent_o <= sel_nxt;
    end
  end

  a_r9_layer_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_o.layers <= LAYER_W'(MAX_LAYERS));

  a_r6_full_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cmd_op_i == OP_VLAN && ent_o.layers >= LAYER_W'(MAX_LAYERS))
      |=> (rsp_err_o && ent_o == $past(ent_o)));

  a_r8_rsp_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> rsp_valid_o);

  a_r8_no_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> !rsp_valid_o && !rsp_err_o);

  a_r7_pppoe_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cmd_op_i == OP_PPPOE) |=> (ent_o.pppoe && ent_o.sid == $past(cmd_sid_i)));

  a_r2_port_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cmd_op_i == OP_PORT)
      |=> (!ent_o.vtag && ent_o.etype[$past(cmd_port_i)] && ent_o.layers != '0));

  a_r10_nop_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cmd_op_i == OP_NOP) |=> (ent_o == $past(ent_o) && !rsp_err_o));
endmodule

// File: rtl/l2_tag_editor.sv
module l2_tag_editor
  import l2te_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_i,
  input  logic               init_v6_i,
  input  logic               cmd_valid_i,
  input  logic [1:0]         cmd_op_i,
  input  logic [PORT_W-1:0]  cmd_port_i,
  input  logic [VID_W-1:0]   cmd_vid_i,
  input  logic [SID_W-1:0]   cmd_sid_i,
  output logic               rsp_valid_o,
  output logic               rsp_err_o,
  output logic [ETYPE_W-1:0] etype_o,
  output logic [VID_W-1:0]   vlan1_o,
  output logic [VID_W-1:0]   vlan2_o,
  output logic [SID_W-1:0]   sid_o,
  output logic [LAYER_W-1:0] layers_o,
  output logic               vtag_o,
  output logic               pppoe_o
);
  entry_t ent, port_nxt, vlan_nxt, pppoe_nxt;
  logic   vlan_full;

  l2te_port_push u_port (
    .cur_i (ent),
    .port_i(cmd_port_i),
    .nxt_o (port_nxt)
  );

  l2te_vlan_push u_vlan (
    .cur_i (ent),
    .vid_i (cmd_vid_i),
    .nxt_o (vlan_nxt),
    .full_o(vlan_full)
  );

  l2te_pppoe_push u_pppoe (
    .cur_i(ent),
    .sid_i(cmd_sid_i),
    .nxt_o(pppoe_nxt)
  );

  l2te_entry_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init_i),
    .init_v6_i  (init_v6_i),
    .cmd_valid_i(cmd_valid_i),
    .cmd_op_i   (op_e'(cmd_op_i)),
    .cmd_port_i (cmd_port_i),
    .cmd_sid_i  (cmd_sid_i),
    .port_nxt_i (port_nxt),
    .vlan_nxt_i (vlan_nxt),
    .vlan_full_i(vlan_full),
    .pppoe_nxt_i(pppoe_nxt),
    .ent_o      (ent),
    .rsp_valid_o(rsp_valid_o),
    .rsp_err_o  (rsp_err_o)
  );

  assign etype_o  = ent.etype;
  assign vlan1_o  = ent.vlan1;
  assign vlan2_o  = ent.vlan2;
  assign sid_o    = ent.sid;
  assign layers_o = ent.layers;
  assign vtag_o   = ent.vtag;
  assign pppoe_o  = ent.pppoe;
endmodule

// File: tb/l2_tag_editor_bench.sv
module l2_tag_editor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init, init_v6, cmd_valid;
  logic [1:0]  cmd_op;
  logic [2:0]  cmd_port;
  logic [11:0] cmd_vid;
  logic [15:0] cmd_sid;
  logic        rsp_valid, rsp_err, vtag, pppoe;
  logic [15:0] etype, sid;
  logic [11:0] vlan1, vlan2;
  logic [1:0]  layers;

  int total = 0;
  int bad   = 0;

  // model state
  logic [15:0] m_etype, m_sid;
  logic [11:0] m_v1, m_v2;
  logic [1:0]  m_lay;
  logic        m_vtag, m_pppoe, m_rv, m_re;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2_tag_editor u_l2_tag_editor (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .init_v6_i(init_v6),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_port_i(cmd_port),
    .cmd_vid_i(cmd_vid), .cmd_sid_i(cmd_sid), .rsp_valid_o(rsp_valid),
    .rsp_err_o(rsp_err), .etype_o(etype), .vlan1_o(vlan1), .vlan2_o(vlan2),
    .sid_o(sid), .layers_o(layers), .vtag_o(vtag), .pppoe_o(pppoe)
  );

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic string tag_for(logic i, logic v, logic [1:0] op);
    if (i) return "R1";
    if (!v) return "R8";
    case (op)
      2'b00: return "R10";
      2'b01: return "R2";
      2'b11: return "R7";
      default: begin
        if (m_lay == 2'd0) return "R3";
        if (m_lay == 2'd1 && !m_vtag) return "R4";
        if (m_lay == 2'd1) return "R5";
        return "R6";
      end
    endcase
  endfunction

  task automatic model_init(logic v6);
    m_etype = v6 ? 16'h86DD : 16'h0800;
    m_sid = '0; m_v1 = '0; m_v2 = '0; m_lay = '0; m_vtag = 0; m_pppoe = 0;
  endtask

  task automatic model_step(logic i, logic v6, logic v, logic [1:0] op,
                            logic [2:0] p, logic [11:0] vid, logic [15:0] s);
    m_rv = 0; m_re = 0;
    if (i) begin model_init(v6); return; end
    if (!v) return;
    m_rv = 1;
    case (op)
      2'b01: begin
        m_etype = 16'(1) << p;
        if (m_lay == 0) m_lay = 1; else m_etype = m_etype | 16'h0100;
        m_vtag = 0;
      end
      2'b10: begin
        if (m_lay == 0) begin m_vtag = 1; m_lay = 1; m_v1 = vid; end
        else if (m_lay == 1 && !m_vtag) begin m_v1 = vid; m_etype = m_etype | 16'h0100; end
        else if (m_lay == 1) begin m_v2 = vid; m_lay = 2; end
        else m_re = 1;
      end
      2'b11: begin
        if (m_lay == 0 || m_vtag) m_etype = 16'h8864;
        m_pppoe = 1; m_sid = s;
      end
      default: ;
    endcase
  endtask

  task automatic compare(string tag);
    logic [59:0] act, exp;
    act = {etype, vlan1, vlan2, sid, layers, vtag, pppoe};
    exp = {m_etype, m_v1, m_v2, m_sid, m_lay, m_vtag, m_pppoe};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s entry: actual=%h expected=%h", tag, act, exp);
    end
    total++;
    if ({rsp_valid, rsp_err} !== {m_rv, m_re}) begin
      bad++;
      $display("FAIL %s/R8 response: actual=%b%b expected=%b%b", tag, rsp_valid, rsp_err, m_rv, m_re);
    end
    total++;
    if (layers > 2'd2) begin
      bad++;
      $display("FAIL R9 layers: actual=%0d expected<=2", layers);
    end
  endtask

  task automatic step(logic i, logic v6, logic v, logic [1:0] op,
                      logic [2:0] p, logic [11:0] vid, logic [15:0] s);
    string tag;
    init = i; init_v6 = v6; cmd_valid = v; cmd_op = op;
    cmd_port = p; cmd_vid = vid; cmd_sid = s;
    tag = tag_for(i, v, op);
    model_step(i, v6, v, op, p, vid, s);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    init = 0; init_v6 = 0; cmd_valid = 0; cmd_op = 0;
    cmd_port = 0; cmd_vid = 0; cmd_sid = 0;
    model_init(1'b0); m_rv = 0; m_re = 0;
    repeat (3) @(negedge clk);
    compare("R1");                       // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R3, R5, R6: VLAN stacking to full then rejected
    step(0, 0, 1, 2'b10, 0, 12'h00A, 0);
    step(0, 0, 1, 2'b10, 0, 12'h00B, 0);
    step(0, 0, 1, 2'b10, 0, 12'h00C, 0);
    // R7 with vtag set, R2 at layer 2 sets bit 8
    step(0, 0, 1, 2'b11, 0, 0, 16'h1234);
    step(0, 0, 1, 2'b01, 3'd5, 0, 0);
    // R7 with vtag clear and layer 2: etype kept
    step(0, 0, 1, 2'b11, 0, 0, 16'h4321);
    // R1 init v6; R2 at layer 0; R4 VLAN behind port tag
    step(1, 1, 0, 2'b00, 0, 0, 0);
    step(0, 0, 1, 2'b01, 3'd7, 0, 0);
    step(0, 0, 1, 2'b10, 0, 12'hFFF, 0);
    // R10 nop; R8 idle
    step(0, 0, 1, 2'b00, 0, 12'h123, 16'hFFFF);
    step(0, 0, 0, 2'b10, 0, 12'h321, 0);
    // R1 init overrides a command
    step(1, 0, 1, 2'b10, 0, 12'h555, 0);
    // R7 at layer 0
    step(0, 0, 1, 2'b11, 0, 0, 16'hBEEF);

    for (int k = 0; k < N_RANDOM; k++) begin
      logic ri;
      ri = ($urandom % 12) == 0;
      step(ri, 1'($urandom), 1'(($urandom % 8) != 0), 2'($urandom),
           3'($urandom), 12'($urandom), 16'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule